// File: doc/BRIEF.md
# Line Burst Bus Master

This block is the external bus master that moves one cache line between the core and the system bus. A line is four longword beats of 32 bits. The core side presents a single request carrying the line address, the transfer direction, four words of write data, a burst-inhibit flag and the termination mode. The block then runs the bus protocol. It drives the transfer-start strobe, the address strobe, the chip select, the read/write line, the transfer-in-progress flag, the size code, the address bus and the data bus. It advances a beat on each clock edge where the transfer acknowledge is sampled high.

A zero-wait-state burst completes in 2-1-1-1 clocks. The first beat takes an address cycle and then a data cycle. Each later beat takes one data cycle. The termination mode sets how the address behaves during a burst. With internal termination the beat index steps through address bits [3:2]. With external termination the address stays at the line base. When bursting is inhibited, the block splits the line into four independent longword accesses, and each access has its own start strobe. When the last beat is acknowledged, the block raises a one-clock completion pulse and presents the four read words in beat order.

Top module: `line_burst_master`

## Requirements
- R1: The first clock of each access drives the start strobe `ts_o` high for exactly one clock, with `data_oe_o` low. On a write, the data word is driven with `data_oe_o` high from the following clock onward.
- R2: A line with `ta_i` held high during data phases keeps `tip_o` high for 5 clocks when bursting. Waits add one clock each. `done_o` rises in the clock after the last `tip_o` clock.
- R3: A burst uses one start strobe. `as_o` and `cs_o` stay high in every clock where `tip_o` is high.
- R4: In a burst with internal termination, address bits [3:2] carry the beat index 0, 1, 2, 3. Bits [AW-1:4] come from the request, and request bits [3:0] are ignored (driven as zero).
- R5: In a burst with external termination, `addr_o` equals the line base (bits [3:0] zero) in every beat.
- R6: With the inhibit flag set, the line runs as four accesses, each with its own `ts_o`. Address bits [3:2] advance 0, 1, 2, 3 across the accesses whatever the termination mode.
- R7: While active, `siz_o` is 2'b11 (line) for a burst and 2'b00 (longword) for inhibited accesses. `rw_o` is 1 for a read and 0 for a write.
- R8: `tip_o` goes high with the first start strobe and stays high until the clock in which the final beat is acknowledged. It is low in the clock after that.
- R9: While `ta_i` is low in a data phase, address, data, size and direction hold steady and the beat does not advance. `ta_i` has no effect while the block is idle.
- R10: `done_o` is a one-clock pulse. For a read, `rdata_o[32k+31:32k]` then holds the word sampled on `data_i` at the acknowledge of beat k.
- R11: `req_i` is sampled only while idle. A request raised during a transfer, with other address or direction, does not alter that transfer and does not start another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Line request, sampled while idle |
| req_addr_i | input | AW | Line address |
| req_write_i | input | 1 | 1 = line write, 0 = line read |
| req_inhibit_i | input | 1 | 1 = split into four longword accesses |
| req_ext_term_i | input | 1 | 1 = external termination, 0 = internal |
| req_wdata_i | input | BEATS*DW | Write words, beat k at bits [DW*k +: DW] |
| ta_i | input | 1 | Transfer acknowledge |
| data_i | input | DW | Read data bus |
| ts_o | output | 1 | Transfer start strobe |
| as_o | output | 1 | Address strobe |
| cs_o | output | 1 | Chip select |
| rw_o | output | 1 | 1 = read, 0 = write |
| tip_o | output | 1 | Transfer in progress |
| siz_o | output | 2 | Size code: 11 line, 00 longword |
| addr_o | output | AW | Address bus |
| data_o | output | DW | Write data bus |
| data_oe_o | output | 1 | Write data drive enable |
| done_o | output | 1 | Line complete pulse |
| rdata_o | output | BEATS*DW | Read words in beat order |

## Verification
The bench uses the defaults: 32-bit address and data and four beats per line. With these values the beat field is address bits [3:2] and the size codes are exact. A line based at the top of the address space then checks that advancing the beat never carries into the upper address bits. The vector table pairs each termination mode and the inhibit flag with per-beat wait counts of zero to three. This lets a wait land on the first beat, on a middle beat or on the last beat, in both directions.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } lbm_state_e;

  localparam logic [1:0] SIZ_LONG = 2'b00;
  localparam logic [1:0] SIZ_LINE = 2'b11;
endpackage

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
#(
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ta_i,
  input  logic              inh_i,
  output lbm_state_e        state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              accept_o,
  output logic              ack_o,
  output logic              done_o
);
  lbm_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q;
  logic              last_ack;

  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign ack_o    = (state_q == ST_DATA) && ta_i;
  assign last_ack = ack_o && (beat_q == BEAT_W'(BEATS - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (last_ack)   state_d = ST_IDLE;
        else if (ack_o) state_d = inh_i ? ST_ADDR : ST_DATA;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= last_ack;
      if (accept_o)                beat_q <= '0;
      else if (ack_o && !last_ack) beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/lbm_addr_gen.sv
module lbm_addr_gen
  import lbm_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int BYTE_W = $clog2(DW / 8),
  localparam int OFS_W  = BEAT_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              active_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              req_inhibit_i,
  input  logic              req_ext_term_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic              inh_o,
  output logic              ext_o,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        siz_o
);
  localparam logic [AW-1:0] OFS_MASK = (AW'(1) << OFS_W) - AW'(1);

  logic [AW-1:0]     base_q;
  logic              inh_q, ext_q;
  logic [BEAT_W-1:0] step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      inh_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else if (accept_i) begin
      base_q <= req_addr_i;
      inh_q  <= req_inhibit_i;
      ext_q  <= req_ext_term_i;
    end
  end

  // external termination holds the line base only while bursting
  assign step   = (ext_q && !inh_q) ? '0 : beat_i;
  assign addr_o = (base_q & ~OFS_MASK) |
                  {{(AW - OFS_W){1'b0}}, step, {BYTE_W{1'b0}}};
  assign siz_o  = (active_i && !inh_q) ? SIZ_LINE : SIZ_LONG;
  assign inh_o  = inh_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/lbm_data_path.sv
module lbm_data_path #(
  parameter int DW     = 32,
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                ack_i,
  input  logic                drive_i,
  input  logic                req_write_i,
  input  logic [BEATS*DW-1:0] req_wdata_i,
  input  logic [BEAT_W-1:0]   beat_i,
  input  logic [DW-1:0]       data_i,
  output logic                write_o,
  output logic [DW-1:0]       data_o,
  output logic                data_oe_o,
  output logic [BEATS*DW-1:0] rdata_o
);
  logic [BEATS*DW-1:0] wdata_q;
  logic                write_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept_i) begin
      wdata_q <= req_wdata_i;
      write_q <= req_write_i;
    end
  end

  assign data_oe_o = drive_i && write_q;
  assign data_o    = data_oe_o ? wdata_q[beat_i*DW +: DW] : '0;
  assign write_o   = write_q;

  for (genvar i = 0; i < BEATS; i++) begin : g_rword
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              word_q <= '0;
      else if (ack_i && !write_q && (beat_i == BEAT_W'(i)))     word_q <= data_i;
    end
    assign rdata_o[i*DW +: DW] = word_q;
  end
endmodule

// File: rtl/line_burst_master.sv
module line_burst_master
  import lbm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic                req_write_i,
  input  logic                req_inhibit_i,
  input  logic                req_ext_term_i,
  input  logic [BEATS*DW-1:0] req_wdata_i,
  input  logic                ta_i,
  input  logic [DW-1:0]       data_i,
  output logic                ts_o,
  output logic                as_o,
  output logic                cs_o,
  output logic                rw_o,
  output logic                tip_o,
  output logic [1:0]          siz_o,
  output logic [AW-1:0]       addr_o,
  output logic [DW-1:0]       data_o,
  output logic                data_oe_o,
  output logic                done_o,
  output logic [BEATS*DW-1:0] rdata_o
);
  lbm_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              accept, ack, active;
  logic              inh_q, ext_q, write_q;

  lbm_seq #(.BEATS(BEATS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .ta_i     (ta_i),
    .inh_i    (inh_q),
    .state_o  (state),
    .beat_o   (beat),
    .accept_o (accept),
    .ack_o    (ack),
    .done_o   (done_o)
  );

  assign active = (state != ST_IDLE);

  lbm_addr_gen #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_addr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (accept),
    .active_i       (active),
    .req_addr_i     (req_addr_i),
    .req_inhibit_i  (req_inhibit_i),
    .req_ext_term_i (req_ext_term_i),
    .beat_i         (beat),
    .inh_o          (inh_q),
    .ext_o          (ext_q),
    .addr_o         (addr_o),
    .siz_o          (siz_o)
  );

  lbm_data_path #(.DW(DW), .BEATS(BEATS)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .ack_i       (ack),
    .drive_i     (state == ST_DATA),
    .req_write_i (req_write_i),
    .req_wdata_i (req_wdata_i),
    .beat_i      (beat),
    .data_i      (data_i),
    .write_o     (write_q),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .rdata_o     (rdata_o)
  );

  assign ts_o  = (state == ST_ADDR);
  assign as_o  = active;
  assign cs_o  = active;
  assign tip_o = active;
  assign rw_o  = active ? !write_q : 1'b1;
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ts_o,
  input logic          as_o,
  input logic          tip_o,
  input logic          rw_o,
  input logic [1:0]    siz_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic          ta_i,
  input logic          done_o,
  input logic          inh_q,
  input logic          ext_q
);
  p_ts_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |=> !ts_o);

  p_wdata_after_ts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_o && !rw_o) |=> data_oe_o);

  p_as_drop_on_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_o) |-> $past(ta_i));

  p_int_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_o && !ts_o && !inh_q && !ext_q && $past(tip_o && !ts_o && ta_i))
      |-> (addr_o[3:2] == $past(addr_o[3:2]) + 2'd1));

  p_ext_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_o && $past(tip_o) && ext_q && !inh_q) |-> $stable(addr_o));

  p_wait_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_o && !ts_o && !ta_i) |=>
      (tip_o && $stable(addr_o) && $stable(data_o) && $stable(siz_o) && $stable(rw_o)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!tip_o && $past(tip_o) && $past(ta_i)));
endmodule

bind line_burst_master lbm_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ts_o      (ts_o),
  .as_o      (as_o),
  .tip_o     (tip_o),
  .rw_o      (rw_o),
  .siz_o     (siz_o),
  .addr_o    (addr_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .ta_i      (ta_i),
  .done_o    (done_o),
  .inh_q     (inh_q),
  .ext_q     (ext_q)
);

// File: tb/line_burst_master_test.sv
`timescale 1ns/1ps
module line_burst_master_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BEATS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0, req_inh = 1'b0, req_ext = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BEATS*DW-1:0] req_wdata = '0;
  logic ta = 1'b0;
  logic [DW-1:0] din = '0;
  logic ts, as_s, cs, rw, tip, data_oe, done;
  logic [1:0] siz;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout;
  logic [BEATS*DW-1:0] rdata;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  line_burst_master #(.AW(AW), .DW(DW), .BEATS(BEATS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .req_write_i(req_wr), .req_inhibit_i(req_inh), .req_ext_term_i(req_ext),
    .req_wdata_i(req_wdata), .ta_i(ta), .data_i(din),
    .ts_o(ts), .as_o(as_s), .cs_o(cs), .rw_o(rw), .tip_o(tip), .siz_o(siz),
    .addr_o(addr), .data_o(dout), .data_oe_o(data_oe), .done_o(done),
    .rdata_o(rdata)
  );

  // addr[43:12] wr[11] inh[10] ext[9] pad[8] waits[7:0] (2 bits per beat)
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {32'h0000_2040, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {32'h0000_400C, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {32'h0000_5128, 1'b1, 1'b0, 1'b1, 1'b0, 8'b01_00_10_00},
    {32'h0000_6200, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {32'h0000_7304, 1'b1, 1'b1, 1'b1, 1'b0, 8'b00_11_00_01},
    {32'h0000_8400, 1'b0, 1'b0, 1'b0, 1'b0, 8'b11_00_00_01},
    {32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  function automatic logic [DW-1:0] wd(logic [AW-1:0] a, int k);
    return a ^ 32'h5A5A_0000 ^ (32'h0101_0101 * k);
  endfunction

  function automatic logic [DW-1:0] rd(logic [AW-1:0] a, int k);
    return ~a ^ 32'h00C3_0000 ^ (32'h0000_0100 << k);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_line(input logic [AW-1:0] a, input bit wr, input bit inh,
                          input bit ext, input logic [7:0] waits, input bit poke);
    int k, wcnt, tsn, tipc, gap, cyc, wsum;
    logic [AW-1:0] base, exp_a;
    bit first;
    base = a & ~32'hF;
    wsum = 0;
    for (int i = 0; i < 4; i++) wsum += int'(waits[2*i +: 2]);
    @(negedge clk);
    req = 1'b1; req_addr = a; req_wr = wr; req_inh = inh; req_ext = ext;
    for (int i = 0; i < BEATS; i++) req_wdata[i*DW +: DW] = wd(a, i);
    k = 0; wcnt = int'(waits[1:0]); tsn = 0; tipc = 0; gap = 0; cyc = 0; first = 1'b1;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) req = 1'b0;
      if (poke && cyc == 2) begin
        req = 1'b1; req_addr = ~a; req_wr = ~wr; req_inh = ~inh; req_ext = ~ext;
      end
      if (poke && cyc == 3) req = 1'b0;
      if (done) break;
      if (first) begin
        chk(ts == 1'b1, "R1 ts on first clock", 64'(ts), 64'd1);
        first = 1'b0;
      end
      if (tip) begin
        tipc++;
        if (!as_s || !cs) gap++;
      end
      exp_a = base | ((inh || !ext) ? AW'(k << 2) : '0);
      if (ts) begin
        tsn++;
        ta = 1'b0;
        chk(data_oe == 1'b0, "R1 no data drive in start clock", 64'(data_oe), 64'd0);
        chk(addr == exp_a, inh ? "R6 access address" : "R4 start address", 64'(addr), 64'(exp_a));
      end else if (tip) begin
        chk(addr == exp_a, inh ? "R6 address" : (ext ? "R5 held address" : "R4 beat address"),
            64'(addr), 64'(exp_a));
        chk(siz == (inh ? 2'b00 : 2'b11), "R7 size code", 64'(siz), 64'(inh ? 2'b00 : 2'b11));
        chk(rw == !wr, "R7 direction", 64'(rw), 64'(!wr));
        if (wr) begin
          chk(data_oe && dout == wd(a, k), "R1 write data", 64'(dout), 64'(wd(a, k)));
        end
        if (wcnt > 0) begin
          ta = 1'b0;
          wcnt--;
        end else begin
          ta = 1'b1;
          din = rd(a, k);
          k++;
          wcnt = (k < 4) ? int'(waits[2*k +: 2]) : 0;
        end
      end else begin
        ta = 1'b0;
      end
    end
    ta = 1'b0;
    chk(done == 1'b1, "R10 done raised", 64'(done), 64'd1);
    chk(k == 4, "R9 beats acknowledged", 64'(k), 64'd4);
    chk(tsn == (inh ? 4 : 1), inh ? "R6 start strobes" : "R3 single start strobe",
        64'(tsn), 64'(inh ? 4 : 1));
    chk(gap == 0, "R3 strobe gap", 64'(gap), 64'd0);
    chk(tipc == (inh ? 8 : 5) + wsum, (wsum == 0 && !inh) ? "R2 2-1-1-1 length" : "R8 tip length",
        64'(tipc), 64'((inh ? 8 : 5) + wsum));
    chk(tip == 1'b0, "R8 tip low at done", 64'(tip), 64'd0);
    if (!wr) begin
      for (int i = 0; i < BEATS; i++)
        chk(rdata[i*DW +: DW] == rd(a, i), "R10 read word order",
            64'(rdata[i*DW +: DW]), 64'(rd(a, i)));
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one clock", 64'(done), 64'd0);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        chk(tip == 1'b0 && ts == 1'b0, "R11 busy request ignored", 64'(tip), 64'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ts == 0 && tip == 0 && as_s == 0 && cs == 0, "R8 reset idle", 64'({ts, tip, as_s, cs}), 64'd0);
    chk(done == 0 && data_oe == 0, "R10 reset done low", 64'({done, data_oe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_line(VEC[v][43:12], VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][7:0], 1'b0);

    // TA while idle
    ta = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(tip == 0 && ts == 0 && done == 0, "R9 idle ta ignored", 64'({tip, ts, done}), 64'd0);
    end
    ta = 1'b0;

    // request raised mid-transfer
    run_line(32'h0000_0100, 1'b0, 1'b0, 1'b0, 8'b00_01_00_00, 1'b1);
    run_line(32'h0000_0A00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule